// File: doc/BRIEF.md
# Separable Two-Dimensional Filterbank Pass Sequencer

This controller runs a bank of separable two-dimensional filters on one processing region. The region holds one one-dimensional filter at a time. For every filter of the bank, the sequencer makes a row pass over the frame. It then asks for the row filter to be replaced by the matching column filter and makes a column pass over the row-processed result. After that it asks for the row filter of the next filter. When the last filter's column pass ends, the bank has been applied to the frame and the sequence starts again with filter 0 on a new frame. The filters themselves, the frame buffering between passes and the transport that replaces a filter all live outside this block.

A replacement is requested with a level request and an index: filter i has index 2·i for its row variant and 2·i+1 for its column variant. The request stays up until a one-cycle done is sampled. For the whole time a replacement is in flight, and while the region is held in reset afterwards, both sides of the region's streams are closed. After each replacement the region gets a reset pulse of a programmable number of cycles. Only then does the next pass open. The sample streams use valid/ready. A sample moves on a side only in a cycle where both valid and ready are high on that side. Ready toward the source and valid toward the sink pass straight through from the region, so back-pressure takes effect in the same cycle. Frame width, frame height, bank size and reset length are run-time inputs. They are captured when the sequencer starts and again at every frame boundary.

Top module: `sfb_pass_seq`

## Requirements
- R1: After reset the block is idle: swp_req, rg_rst, frame_done, m_valid, s_ready, rg_in_valid and rg_out_ready are 0, m_data is 0 and iso is 1. No request is made while run stays 0.
- R2: When run is 1 in the idle state, the first request carries index 0, which is the row variant of filter 0.
- R3: Within a frame the request indices are 0, 1, 2, … 2K−1 in that order, where index 2·i+c selects filter i and c=1 marks the column variant. The first request of each following frame is index 0 again.
- R4: Once raised, swp_req stays 1 with swp_idx unchanged until swp_done is sampled 1. It falls in the cycle after that.
- R5: Whenever no pass is open (idle, request pending, or reset pulse), iso is 1 and m_valid, m_data, rg_out_ready, rg_in_valid and s_ready are all 0.
- R6: rg_rst rises in the cycle after swp_done is sampled. It stays 1 for exactly max(cfg_rst_len,1) consecutive cycles, and only while iso is 1. The pass opens in the cycle after rg_rst falls.
- R7: Each pass takes exactly width·height input handshakes, after which s_ready stays 0. The pass ends on its width·height-th output handshake, and the next request or idle follows in the next cycle.
- R8: Inside a pass, samples move only on valid-and-ready handshakes on each side, with ready and valid passed through in the same cycle. No sample is dropped, duplicated or reordered under random stalls on either side.
- R9: During a pass, pass_col equals bit 0 of the last request index and flt_idx equals the remaining upper bits.
- R10: frame_done is a one-cycle pulse at the end of the column pass of the last filter, so one pulse marks one completed frame.
- R11: Width, height, bank size and reset length are captured only at a run start or at a frame boundary, so changes in mid-frame take effect from the next frame. A value of 0 counts as 1, and a bank size above MAX_FLT counts as MAX_FLT.
- R12: If run is 0 when a frame ends, the block returns to idle and makes no further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Start and keep sequencing frames |
| cfg_width | input | W_BITS | Samples per line |
| cfg_height | input | H_BITS | Lines per frame |
| cfg_nflt | input | clog2(MAX_FLT+1) | Number of filters in the bank |
| cfg_rst_len | input | RL_W | Region reset pulse length in cycles |
| swp_req | output | 1 | Filter replacement request |
| swp_idx | output | clog2(MAX_FLT)+1 | Index of the filter variant to load |
| swp_done | input | 1 | Replacement finished (one-cycle pulse) |
| rg_rst | output | 1 | Reset into the processing region |
| iso | output | 1 | Region isolated (no pass open) |
| pass_col | output | 1 | Current pass is a column pass |
| flt_idx | output | clog2(MAX_FLT) | Current filter of the bank |
| frame_done | output | 1 | Pulse: whole bank applied to a frame |
| s_valid | input | 1 | Source sample valid |
| s_ready | output | 1 | Source sample ready |
| s_data | input | DW | Source sample |
| rg_in_valid | output | 1 | Sample valid into the region |
| rg_in_ready | input | 1 | Region ready for a sample |
| rg_in_data | output | DW | Sample into the region |
| rg_out_valid | input | 1 | Region result valid |
| rg_out_ready | output | 1 | Ready toward the region result |
| rg_out_data | input | DW | Region result |
| m_valid | output | 1 | Result valid toward the sink |
| m_ready | input | 1 | Sink ready |
| m_data | output | DW | Result toward the sink |

## Verification
The request rises one cycle after a pass's final output handshake, and rg_rst rises one cycle after done is sampled. The bench therefore drives every input one time unit after a rising edge and samples all outputs on the falling edge. Each result is compared at the falling edge where its due cycle falls: the request index and stream closure when the request first shows, reset high at the falling edge right after done was taken, and the reset length counted in falling edges until rg_rst drops. The stream side has no added latency, because valid and ready pass through. Each output handshake seen at a falling edge is matched in order against a scoreboard entry that was pushed when the matching input handshake was seen. Per-pass handshake counts are checked when the following request appears.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SWAP = 2'd1,
    ST_RSTP = 2'd2,
    ST_PASS = 2'd3
  } seq_state_t;
endpackage

// File: rtl/sfb_pass_cnt.sv
module sfb_pass_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] total,
  output logic             hit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign hit = step && !done && (cnt == total - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (step && !done) begin
      cnt <= cnt + CNT_W'(1);
      if (hit) done <= 1'b1;
    end
  end

  AST_NO_STEP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |-> !step);  // R7
endmodule

// File: rtl/sfb_rst_pulser.sv
module sfb_rst_pulser #(
  parameter int RL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [RL_W-1:0] len,
  output logic            active,
  output logic            fin
);
  logic [RL_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len;
    else if (cnt != '0)  cnt <= cnt - RL_W'(1);
  end

  assign active = (cnt != '0);
  assign fin    = (cnt == RL_W'(1));

  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && len != '0) |=> active);  // R6
  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !load) |=> !active);  // R6
endmodule

// File: rtl/sfb_stream_gate.sv
module sfb_stream_gate #(
  parameter int DW = 16
) (
  input  logic          open_in,
  input  logic          open_out,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          rg_in_valid,
  input  logic          rg_in_ready,
  output logic [DW-1:0] rg_in_data,
  input  logic          rg_out_valid,
  output logic          rg_out_ready,
  input  logic [DW-1:0] rg_out_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);
  assign rg_in_valid  = s_valid && open_in;
  assign s_ready      = rg_in_ready && open_in;
  assign rg_in_data   = open_in ? s_data : '0;
  assign m_valid      = rg_out_valid && open_out;
  assign rg_out_ready = m_ready && open_out;
  assign m_data       = open_out ? rg_out_data : '0;
endmodule

// File: rtl/sfb_pass_seq.sv
module sfb_pass_seq
  import sfb_pkg::*;
#(
  parameter int DW      = 16,
  parameter int W_BITS  = 8,
  parameter int H_BITS  = 8,
  parameter int MAX_FLT = 4,
  parameter int RL_W    = 4,
  localparam int FLT_W  = (MAX_FLT > 1) ? $clog2(MAX_FLT) : 1,
  localparam int NF_W   = $clog2(MAX_FLT + 1),
  localparam int IDX_W  = FLT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [W_BITS-1:0] cfg_width,
  input  logic [H_BITS-1:0] cfg_height,
  input  logic [NF_W-1:0]   cfg_nflt,
  input  logic [RL_W-1:0]   cfg_rst_len,
  output logic              swp_req,
  output logic [IDX_W-1:0]  swp_idx,
  input  logic              swp_done,
  output logic              rg_rst,
  output logic              iso,
  output logic              pass_col,
  output logic [FLT_W-1:0]  flt_idx,
  output logic              frame_done,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DW-1:0]     s_data,
  output logic              rg_in_valid,
  input  logic              rg_in_ready,
  output logic [DW-1:0]     rg_in_data,
  input  logic              rg_out_valid,
  output logic              rg_out_ready,
  input  logic [DW-1:0]     rg_out_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DW-1:0]     m_data
);
  localparam int CNT_W = W_BITS + H_BITS;

  seq_state_t        st;
  logic [W_BITS-1:0] lw, w_cl;
  logic [H_BITS-1:0] lh, h_cl;
  logic [FLT_W-1:0]  lk_last;
  logic [RL_W-1:0]   lrl, rl_cl;
  logic [NF_W-1:0]   k_cl, k_m1;
  logic [FLT_W-1:0]  flt;
  logic              col;
  logic [CNT_W-1:0]  frm_total;
  logic              in_hit, in_done, out_hit, out_done;
  logic              rp_active, rp_fin;
  logic              in_pass, open_in;

  // run-time settings with zero and overrange clamped
  always_comb begin
    w_cl  = (cfg_width  == '0) ? W_BITS'(1) : cfg_width;
    h_cl  = (cfg_height == '0) ? H_BITS'(1) : cfg_height;
    rl_cl = (cfg_rst_len == '0) ? RL_W'(1) : cfg_rst_len;
    if (cfg_nflt == '0)                   k_cl = NF_W'(1);
    else if (cfg_nflt > NF_W'(MAX_FLT))   k_cl = NF_W'(MAX_FLT);
    else                                  k_cl = cfg_nflt;
    k_m1 = k_cl - NF_W'(1);
  end

  assign frm_total = CNT_W'(lw) * CNT_W'(lh);
  assign in_pass   = (st == ST_PASS);
  assign open_in   = in_pass && !in_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      flt        <= '0;
      col        <= 1'b0;
      lw         <= W_BITS'(1);
      lh         <= H_BITS'(1);
      lk_last    <= '0;
      lrl        <= RL_W'(1);
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (st)
        ST_IDLE: if (run) begin
          lw      <= w_cl;
          lh      <= h_cl;
          lrl     <= rl_cl;
          lk_last <= k_m1[FLT_W-1:0];
          flt     <= '0;
          col     <= 1'b0;
          st      <= ST_SWAP;
        end
        ST_SWAP: if (swp_done) st <= ST_RSTP;
        ST_RSTP: if (rp_fin) st <= ST_PASS;
        ST_PASS: if (out_hit) begin
          if (!col) begin
            col <= 1'b1;
            st  <= ST_SWAP;
          end else begin
            col <= 1'b0;
            if (flt == lk_last) begin
              flt        <= '0;
              frame_done <= 1'b1;
              if (run) begin
                lw      <= w_cl;
                lh      <= h_cl;
                lrl     <= rl_cl;
                lk_last <= k_m1[FLT_W-1:0];
                st      <= ST_SWAP;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              flt <= flt + FLT_W'(1);
              st  <= ST_SWAP;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign swp_req  = (st == ST_SWAP);
  assign swp_idx  = {flt, col};
  assign iso      = !in_pass;
  assign pass_col = col;
  assign flt_idx  = flt;
  assign rg_rst   = rp_active;

  sfb_rst_pulser #(.RL_W(RL_W)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (swp_req && swp_done),
    .len    (lrl),
    .active (rp_active),
    .fin    (rp_fin)
  );

  sfb_pass_cnt #(.CNT_W(CNT_W)) u_in_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_pass),
    .step  (s_valid && s_ready),
    .total (frm_total),
    .hit   (in_hit),
    .done  (in_done)
  );

  sfb_pass_cnt #(.CNT_W(CNT_W)) u_out_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_pass),
    .step  (m_valid && m_ready),
    .total (frm_total),
    .hit   (out_hit),
    .done  (out_done)
  );

  sfb_stream_gate #(.DW(DW)) u_gate (
    .open_in      (open_in),
    .open_out     (in_pass),
    .s_valid      (s_valid),
    .s_ready      (s_ready),
    .s_data       (s_data),
    .rg_in_valid  (rg_in_valid),
    .rg_in_ready  (rg_in_ready),
    .rg_in_data   (rg_in_data),
    .rg_out_valid (rg_out_valid),
    .rg_out_ready (rg_out_ready),
    .rg_out_data  (rg_out_data),
    .m_valid      (m_valid),
    .m_ready      (m_ready),
    .m_data       (m_data)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (swp_req && !swp_done) |=> (swp_req && $stable(swp_idx)));  // R4
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (swp_req && swp_done) |=> !swp_req);  // R4
  AST_ISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    iso |-> (!m_valid && !rg_out_ready && !s_ready && !rg_in_valid));  // R5
  AST_RST_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    rg_rst |-> iso);  // R6
  AST_DONE_TO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (swp_req && swp_done) |=> rg_rst);  // R6
  AST_IN_BEFORE_LAST_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> (in_done || in_hit));  // R7
  AST_IN_HIT_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_hit |-> in_pass);  // R7
  AST_PASS_NOT_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    in_pass |-> !out_done);  // R7
  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);  // R10
endmodule

// File: tb/sfb_pass_seq_bench.sv
module sfb_pass_seq_bench;
  localparam int DW = 16;
  localparam int W_BITS = 8;
  localparam int H_BITS = 8;
  localparam int MAX_FLT = 4;
  localparam int RL_W = 4;
  localparam int FLT_W = 2;
  localparam int NF_W = 3;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [W_BITS-1:0] cfg_width = 8'd3;
  logic [H_BITS-1:0] cfg_height = 8'd2;
  logic [NF_W-1:0] cfg_nflt = 3'd3;
  logic [RL_W-1:0] cfg_rst_len = 4'd2;
  logic swp_req, swp_done = 1'b0;
  logic [IDX_W-1:0] swp_idx;
  logic rg_rst, iso, pass_col, frame_done;
  logic [FLT_W-1:0] flt_idx;
  logic s_valid = 1'b0, s_ready;
  logic [DW-1:0] s_data = 16'h0010;
  logic rg_in_valid, rg_in_ready, rg_out_valid, rg_out_ready;
  logic [DW-1:0] rg_in_data, rg_out_data;
  logic m_valid, m_ready = 1'b0;
  logic [DW-1:0] m_data;

  always #4 clk = ~clk;

  sfb_pass_seq #(.DW(DW), .W_BITS(W_BITS), .H_BITS(H_BITS), .MAX_FLT(MAX_FLT), .RL_W(RL_W)) u_sfb_pass_seq (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_nflt(cfg_nflt), .cfg_rst_len(cfg_rst_len),
    .swp_req(swp_req), .swp_idx(swp_idx), .swp_done(swp_done),
    .rg_rst(rg_rst), .iso(iso), .pass_col(pass_col), .flt_idx(flt_idx), .frame_done(frame_done),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .rg_in_valid(rg_in_valid), .rg_in_ready(rg_in_ready), .rg_in_data(rg_in_data),
    .rg_out_valid(rg_out_valid), .rg_out_ready(rg_out_ready), .rg_out_data(rg_out_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  // behavioural region: one-entry buffer that tags samples with the loaded variant
  logic [IDX_W-1:0] ld_idx;
  logic bv;
  logic [DW-1:0] bd;
  assign rg_in_ready  = !bv || rg_out_ready;
  assign rg_out_valid = bv;
  assign rg_out_data  = bd;
  always_ff @(posedge clk) begin
    if (!rst_n || rg_rst) bv <= 1'b0;
    else if (rg_in_valid && rg_in_ready) begin
      bv <= 1'b1;
      bd <= rg_in_data + {5'd0, ld_idx, 8'd0};
    end else if (rg_out_ready) bv <= 1'b0;
  end
  always_ff @(posedge clk) begin
    if (!rst_n) ld_idx <= '0;
    else if (swp_req && swp_done) ld_idx <= swp_idx;
  end

  int nchk = 0, nfail = 0;
  bit fin = 0;
  logic [IDX_W-1:0] iq[$];
  logic [DW-1:0] dq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_frame(input int k);
    for (int i = 0; i < 2 * k; i++) iq.push_back(IDX_W'(i));
  endtask

  // swap responder with random latency
  int lat = 2;
  initial begin
    forever begin
      @(posedge clk); #1;
      if (swp_done) swp_done = 1'b0;
      else if (swp_req) begin
        if (lat == 0) begin
          swp_done = 1'b1;
          lat = $urandom_range(0, 5);
        end else lat--;
      end
    end
  end

  // source driver: valid held until accepted, expected result pushed on acceptance
  initial begin
    bit acc;
    forever begin
      @(negedge clk);
      acc = s_valid && s_ready;
      if (acc) dq.push_back(s_data + {5'd0, ld_idx, 8'd0});
      @(posedge clk); #1;
      if (acc) s_data = s_data + 16'd1;
      if (!s_valid || acc) s_valid = ($urandom_range(0, 3) != 0);
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      m_ready = ($urandom_range(0, 3) != 0);
    end
  end

  // monitor
  int frames = 0, in_cnt = 0, out_cnt = 0, rst_run = 0, exp_wh = 1, exp_rl = 1;
  bit prev_req = 0, done_seen = 0, first_req = 1;
  logic [IDX_W-1:0] cur_idx = '0, prev_idx = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (m_valid && m_ready) begin
          if (dq.size() == 0) chk(0, "R8 unexpected output", int'(m_data), -1);
          else begin
            logic [DW-1:0] e;
            e = dq.pop_front();
            chk(m_data == e, "R8 result data", int'(m_data), int'(e));
          end
          chk({flt_idx, pass_col} == cur_idx, "R9 pass id", int'({flt_idx, pass_col}), int'(cur_idx));
          out_cnt++;
        end
        if (s_valid && s_ready) in_cnt++;
        if (done_seen) chk(rg_rst == 1'b1, "R6 reset after done", int'(rg_rst), 1);
        done_seen = swp_req && swp_done;
        if (rg_rst) rst_run++;
        else if (rst_run != 0) begin
          chk(rst_run == exp_rl, "R6 reset length", rst_run, exp_rl);
          rst_run = 0;
        end
        if (swp_req && !prev_req) begin
          if (!first_req) begin
            chk(in_cnt == exp_wh, (frames == 1) ? "R11 input count" : "R7 input count", in_cnt, exp_wh);
            chk(out_cnt == exp_wh, "R7 output count", out_cnt, exp_wh);
          end
          in_cnt = 0;
          out_cnt = 0;
          chk(iso && !m_valid && !s_ready && !rg_in_valid && !rg_out_ready && m_data == '0,
              "R5 closed during swap", int'({m_valid, s_ready, rg_in_valid, rg_out_ready}), 0);
          if (iq.size() == 0) chk(0, "R3 unexpected request", int'(swp_idx), -1);
          else begin
            logic [IDX_W-1:0] e;
            e = iq.pop_front();
            chk(swp_idx == e, first_req ? "R2 first index" : "R3 index order", int'(swp_idx), int'(e));
          end
          if (swp_idx == '0) begin
            exp_wh = ((cfg_width == 0) ? 1 : int'(cfg_width)) * ((cfg_height == 0) ? 1 : int'(cfg_height));
            exp_rl = (cfg_rst_len == 0) ? 1 : int'(cfg_rst_len);
          end
          cur_idx = swp_idx;
          first_req = 0;
        end
        if (swp_req && prev_req && swp_idx != prev_idx)
          chk(0, "R4 index moved", int'(swp_idx), int'(prev_idx));
        if (frame_done) frames++;
        prev_req = swp_req;
        prev_idx = swp_idx;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R10: actual %0d frames expected 4", frames);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(swp_req == 0, "R1 no request", int'(swp_req), 0);
    chk(iso == 1, "R1 isolated", int'(iso), 1);
    chk(rg_rst == 0 && frame_done == 0, "R1 reset and frame low", int'({rg_rst, frame_done}), 0);
    chk(!m_valid && !s_ready && !rg_in_valid && !rg_out_ready && m_data == '0, "R1 streams closed",
        int'({m_valid, s_ready, rg_in_valid, rg_out_ready}), 0);
    repeat (10) @(negedge clk);
    chk(swp_req == 0, "R1 idle while run low", int'(swp_req), 0);
    push_frame(3);
    push_frame(3);
    push_frame(1);
    push_frame(1);
    @(posedge clk); #1 run = 1'b1;
    while (frames < 1) @(negedge clk);
    repeat (3) @(posedge clk);
    #1;
    cfg_width = 8'd4; cfg_height = 8'd1; cfg_nflt = 3'd1; cfg_rst_len = 4'd0;
    while (frames < 3) @(negedge clk);
    repeat (3) @(posedge clk);
    #1 run = 1'b0;
    while (frames < 4) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(swp_req == 0 && iso == 1, "R12 back to idle", int'({swp_req, iso}), 1);
    chk(iq.size() == 0, "R12 all requests seen", iq.size(), 0);
    chk(frames == 4, "R10 frame count", frames, 4);
    chk(in_cnt == exp_wh, "R7 last pass input count", in_cnt, exp_wh);
    chk(dq.size() == 0, "R8 no result left", dq.size(), 0);
    fin = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule